// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block keeps the status byte of a serial flash device and judges every decoded write-type request against it. A command decoder upstream presents one request at a time as a single-cycle pulse on `req_valid`, with an operation code, a byte address and a status data byte. One cycle later the unit answers with a single-cycle `grant` or `reject`. A granted program, erase or status write starts an internal cycle, shown by the busy bit, and a timing counter ends that cycle with a pulse on `cycle_done`.

Protection has two layers. Three block-protect bits pick how many 64 KB sectors, counted down from the top of the array, refuse program and sector-erase requests. A status-lock bit, when combined with a low level on the external protect pin, freezes the protection bits themselves. All pins are plain control and status signals. There is no back-pressure: each request receives a verdict on the following cycle, and it never waits.

Top module: `flash_sp_unit`

## Requirements
- R1: After reset, `status` is 00h, `busy` is 0, and neither `grant` nor `reject` is asserted.
- R2: Operation code 0 (write enable) sets the latch bit and code 1 (write disable) clears it. When the unit is idle, both are granted one cycle after the request. `grant` and `reject` are never high together.
- R3: Codes 2 (page program), 3 (sector erase), 4 (bulk erase) and 5 (status write) are rejected unless the latch bit is 1. Codes 6 and 7 are always rejected. A rejected request changes nothing.
- R4: A granted code 2 to 5 sets the busy bit and `busy` one cycle after the request. A `cycle_done` pulse while busy clears both the busy bit and the latch bit. A `cycle_done` pulse while idle is ignored.
- R5: Every request that arrives while busy is rejected and leaves `status` unchanged.
- R6: A granted status write copies data bits 4:2 into the protect field and data bit 7 into the lock bit. All other data bits are ignored.
- R7: While the lock bit is 1 and `wp_n` is low, status writes are rejected, and the protect field and the lock bit stay constant.
- R8: With protect value b, no sector is protected when b is 0. For b from 1 to 7, the top min(2^(b-1), 16) sectors are protected. Page program and sector erase aimed at a protected sector, chosen by address bits 19:16, are rejected.
- R9: Bulk erase is rejected whenever the protect value is nonzero.
- R10: Any rejected request leaves the latch bit at its previous value.
- R11: The status layout is: bit 0 busy, bit 1 latch, bits 4:2 protect value, bit 7 lock. Bits 6:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Operation code (see R2, R3) |
| req_addr | input | 20 | Target byte address |
| req_data | input | 8 | New status value for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cycle_done | input | 1 | End-of-cycle pulse from the timing counter |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted (one cycle) |
| reject | output | 1 | Request refused (one cycle) |
| busy | output | 1 | Internal cycle in progress |

## Verification
The bench builds the unit with its default parameters: a 20-bit address and 64 KB sectors, which gives 16 sectors. With these values all seven nonzero protect settings are in reach, including the settings 5 to 7 where the protected count saturates at the whole array. The bench sweeps a program request across every sector for each setting. It also drives the lock pin in both states, and it sends requests while the unit is busy as well as done pulses while it is idle.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    OP_WEN    = 3'd0,
    OP_WDIS   = 3'd1,
    OP_PROG   = 3'd2,
    OP_SERASE = 3'd3,
    OP_BERASE = 3'd4,
    OP_WSTAT  = 3'd5
  } fsp_op_e;

  localparam int BP_W      = 3;
  localparam int BP_LO_BIT = 2;
  localparam int LOCK_BIT  = 7;
endpackage

// File: rtl/fsp_region_map.sv
module fsp_region_map #(
  parameter int ADDR_W       = 20,
  parameter int SECT_BYTES_W = 16,
  parameter int BP_W         = 3
) (
  input  logic [BP_W-1:0]   bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              any_prot
);
  localparam int IDX_W   = ADDR_W - SECT_BYTES_W;
  localparam int SECTORS = 1 << IDX_W;

  logic [IDX_W:0]     prot_cnt;
  logic [SECTORS-1:0] sect_prot;

  always_comb begin
    if (bp == '0)
      prot_cnt = '0;
    else if ((int'(bp) - 1) >= IDX_W)
      prot_cnt = (IDX_W+1)'(SECTORS);
    else
      prot_cnt = (IDX_W+1)'(1) << (bp - BP_W'(1));
  end

  for (genvar s = 0; s < SECTORS; s++) begin : g_sect
    assign sect_prot[s] = (int'(prot_cnt) + s) >= SECTORS;
  end

  assign hit      = sect_prot[addr[ADDR_W-1:SECT_BYTES_W]];
  assign any_prot = |sect_prot;
endmodule

// File: rtl/fsp_gate.sv
module fsp_gate
  import fsp_pkg::*;
(
  input  logic    valid,
  input  fsp_op_e op,
  input  logic    wip,
  input  logic    wel,
  input  logic    lock,
  input  logic    wp_n,
  input  logic    hit,
  input  logic    any_prot,
  output logic    accept
);
  logic allowed;

  always_comb begin
    unique case (op)
      OP_WEN, OP_WDIS:     allowed = 1'b1;
      OP_PROG, OP_SERASE:  allowed = wel && !hit;
      OP_BERASE:           allowed = wel && !any_prot;
      OP_WSTAT:            allowed = wel && !(lock && !wp_n);
      default:             allowed = 1'b0;
    endcase
  end

  assign accept = valid && !wip && allowed;
endmodule

// File: rtl/fsp_status_reg.sv
module fsp_status_reg
  import fsp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            accept,
  input  fsp_op_e         op,
  input  logic [7:0]      wdata,
  input  logic            cycle_done,
  output logic            wip,
  output logic            wel,
  output logic [BP_W-1:0] bp,
  output logic            lock,
  output logic            grant,
  output logic            reject
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wip    <= 1'b0;
      wel    <= 1'b0;
      bp     <= '0;
      lock   <= 1'b0;
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= valid && accept;
      reject <= valid && !accept;
      if (wip && cycle_done) begin
        wip <= 1'b0;
        wel <= 1'b0;
      end
      if (accept) begin
        unique case (op)
          OP_WEN:  wel <= 1'b1;
          OP_WDIS: wel <= 1'b0;
          OP_PROG, OP_SERASE, OP_BERASE: wip <= 1'b1;
          OP_WSTAT: begin
            wip  <= 1'b1;
            bp   <= wdata[BP_LO_BIT +: BP_W];
            lock <= wdata[LOCK_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip && cycle_done) |-> (!wip && !wel)); // R4
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject)); // R2
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip && valid) |-> reject); // R5
endmodule

// File: rtl/flash_sp_unit.sv
module flash_sp_unit
  import fsp_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECT_BYTES_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wp_n,
  input  logic              cycle_done,
  output logic [7:0]        status,
  output logic              grant,
  output logic              reject,
  output logic              busy
);
  fsp_op_e         op;
  logic            wip, wel, lock, hit, any_prot, accept;
  logic [BP_W-1:0] bp;

  assign op = fsp_op_e'(req_op);

  fsp_region_map #(
    .ADDR_W(ADDR_W), .SECT_BYTES_W(SECT_BYTES_W), .BP_W(BP_W)
  ) u_map (
    .bp(bp), .addr(req_addr), .hit(hit), .any_prot(any_prot)
  );

  fsp_gate u_gate (
    .valid(req_valid), .op(op), .wip(wip), .wel(wel), .lock(lock),
    .wp_n(wp_n), .hit(hit), .any_prot(any_prot), .accept(accept)
  );

  fsp_status_reg u_reg (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .accept(accept), .op(op),
    .wdata(req_data), .cycle_done(cycle_done), .wip(wip), .wel(wel),
    .bp(bp), .lock(lock), .grant(grant), .reject(reject)
  );

  assign status = {lock, 2'b00, bp, wel, wip};
  assign busy   = wip;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock && !wp_n) |-> $stable({lock, bp})); // R7
  AST_PROT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && (op == OP_PROG || op == OP_SERASE) && hit) |-> reject); // R8
  AST_BULK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && op == OP_BERASE && bp != '0) |-> reject); // R9
endmodule

// File: tb/flash_sp_unit_bench.sv
module flash_sp_unit_bench;
  localparam logic [2:0] C_WEN = 3'd0, C_WDIS = 3'd1, C_PROG = 3'd2,
                         C_SER = 3'd3, C_BULK = 3'd4, C_WST = 3'd5;

  logic        clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wp_n = 1'b1, cycle_done = 1'b0;
  logic [2:0]  req_op = '0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [7:0]  status;
  logic        grant, reject, busy;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  flash_sp_unit u_flash_sp_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wp_n(wp_n),
    .cycle_done(cycle_done), .status(status), .grant(grant),
    .reject(reject), .busy(busy)
  );

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [19:0] addr, logic [7:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_cycle();
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
  endtask

  function automatic bit exp_prot(int b, int s);
    int c;
    if (b == 0) c = 0;
    else if (b - 1 >= 4) c = 16;
    else c = 1 << (b - 1);
    return s >= 16 - c;
  endfunction

  task automatic set_bp(int b);
    issue(C_WEN, '0, '0);
    issue(C_WST, '0, 8'(b << 2));
    finish_cycle();
    check("R6 protect set", status, b << 2);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h00);
    check("R1 busy", busy, 0);
    check("R1 verdicts", {grant, reject}, 0);
  endtask

  task automatic t_latch();
    issue(C_PROG, 20'h00100, '0);
    check("R3 no latch reject", reject, 1);
    check("R3 R10 status kept", status, 8'h00);
    issue(C_WEN, '0, '0);
    check("R2 enable grant", grant, 1);
    check("R2 R11 latch bit", status, 8'h02);
    issue(C_WDIS, '0, '0);
    check("R2 disable grant", grant, 1);
    check("R2 latch cleared", status, 8'h00);
    issue(3'd6, '0, '0);
    check("R3 code6 reject", reject, 1);
    issue(C_WEN, '0, '0);
    issue(3'd7, '0, '0);
    check("R3 code7 reject", reject, 1);
    check("R10 latch kept code7", status, 8'h02);
    issue(C_WDIS, '0, '0);
  endtask

  task automatic t_status_write();
    issue(C_WEN, '0, '0);
    issue(C_WST, '0, 8'hFF);
    check("R6 wstat grant", grant, 1);
    check("R6 R11 status", status, 8'h9F);
    check("R4 busy", busy, 1);
    issue(C_WEN, '0, '0);
    check("R5 busy reject", reject, 1);
    check("R5 status held", status, 8'h9F);
    finish_cycle();
    check("R4 done clears", status, 8'h9C);
    check("R4 busy low", busy, 0);
    finish_cycle();
    check("R4 idle done ignored", status, 8'h9C);
    wp_n = 1'b0;
    issue(C_WEN, '0, '0);
    issue(C_WST, '0, 8'h00);
    check("R7 locked reject", reject, 1);
    check("R7 R10 status", status, 8'h9E);
    wp_n = 1'b1;
    issue(C_WST, '0, 8'h00);
    check("R7 unlocked grant", grant, 1);
    check("R6 cleared", status, 8'h03);
    finish_cycle();
    check("R4 idle after", status, 8'h00);
  endtask

  task automatic t_regions();
    for (int b = 0; b < 8; b++) begin
      set_bp(b);
      for (int s = 0; s < 16; s++) begin
        bit p;
        p = exp_prot(b, s);
        issue(C_WEN, '0, '0);
        issue(C_PROG, 20'((s << 16) | 16'h0123), '0);
        check($sformatf("R8 bp%0d sect%0d grant", b, s), grant, p ? 0 : 1);
        check($sformatf("R8 R10 bp%0d sect%0d status", b, s), status,
              (b << 2) | (p ? 2 : 3));
        if (p) issue(C_WDIS, '0, '0);
        else finish_cycle();
      end
      issue(C_WEN, '0, '0);
      issue(C_SER, 20'hF0000, '0);
      check($sformatf("R8 erase top bp%0d", b), grant, (b == 0) ? 1 : 0);
      if (b == 0) finish_cycle(); else issue(C_WDIS, '0, '0);
      issue(C_WEN, '0, '0);
      issue(C_BULK, '0, '0);
      check($sformatf("R9 bulk bp%0d", b), grant, (b == 0) ? 1 : 0);
      check($sformatf("R9 R10 bulk status bp%0d", b), status,
            (b << 2) | ((b == 0) ? 3 : 2));
      if (b == 0) finish_cycle(); else issue(C_WDIS, '0, '0);
    end
    set_bp(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_status_write();
    t_regions();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule